// File: doc/BRIEF.md
# SD/MMC Card Clock Generator with Sample Strobes and Response Watchdog

This block produces the card clock of an SD/MMC host from the system clock. The low and high phases of each card clock period are set separately, each as a number of system clock cycles. Host software normally writes the same value to both, computed as the system frequency divided by twice the card frequency and rounded up. This gives a duty cycle close to 50 %, and software keeps the card clock between 400 kHz during identification and 52 MHz at most. A new setting is first held in a pending register. The generator only adopts it when the current period has finished, so the card clock never carries a shortened pulse.

A configuration write carries a slot selector. Clock settings are captured only when that selector is zero. A write that addresses any other slot leaves the clock untouched. Software therefore writes with slot zero first, then retargets.

Two sample strobes, one for the command line and one for the data lines, each fire a programmable number of system cycles after every rising card clock edge. This compensates for board skew. A watchdog counts card clock periods, not system cycles, from a start strobe given by the command engine. It pulses a timeout flag once when the programmed limit is reached.

Top module: `sdmmc_clk_wdog`

## Requirements
- R1: During reset, and in the first cycle after it, card_clk, cmd_smp, dat_smp and wd_timeout are all 0. Both phase counts start at the DEF_LO and DEF_HI parameters, and the pending counts start at the same values.
- R2: Each card clock period begins with a low phase of exactly LO system cycles (card_clk = 0). It is followed by a high phase of exactly HI system cycles (card_clk = 1), with no gap between periods.
- R3: A phase count of 0 is used as 1, so hi = lo = 0 gives a period of 2 cycles.
- R4: A configuration write (cfg_wr = 1) updates the pending counts only when cfg_slot = 0. A write with any nonzero cfg_slot has no effect on the card clock.
- R5: Pending counts become active only when a high phase ends, which is the falling card clock edge. The period in progress keeps its old low and high lengths.
- R6: cmd_smp is a single-cycle pulse for each rising card clock edge. It occurs D system cycles after the first cycle in which card_clk is 1, where D is smp_cmd_dly as sampled at that edge. With D = 0 it coincides with that first high cycle. A new rising edge restarts a pending delay.
- R7: dat_smp behaves as in R6 but uses its own delay, smp_dat_dly, independent of the command strobe.
- R8: After a cycle with wd_start = 1, wd_timeout is 1 for exactly one cycle. That cycle is the first high cycle of the L-th rising card clock edge after the start, where L is wd_limit as sampled with the start. The watchdog then stays idle until the next start.
- R9: A start while the watchdog is counting restarts it from zero. A rising edge that coincides with the start cycle is not counted.
- R10: A limit of 0 disables the timeout: no pulse follows such a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Clock configuration write strobe |
| cfg_slot | input | SLOT_W | Slot selector of the write; only 0 is accepted |
| cfg_hi | input | PH_W | High phase length in system cycles |
| cfg_lo | input | PH_W | Low phase length in system cycles |
| smp_cmd_dly | input | SMP_W | Command line sample delay in system cycles |
| smp_dat_dly | input | SMP_W | Data line sample delay in system cycles |
| wd_limit | input | WD_W | Watchdog limit in card clock periods |
| wd_start | input | 1 | Watchdog start/clear strobe from the command engine |
| card_clk | output | 1 | Card clock |
| cmd_smp | output | 1 | Command line sample strobe |
| dat_smp | output | 1 | Data line sample strobe |
| wd_timeout | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds the block with 6-bit phase counts, 4-bit sample delays, an 8-bit watchdog limit and a 2-bit slot selector, with default phases of 3 cycles. These narrow widths keep card clock periods to a few system cycles. As a result, period changes, slot-filtered writes, zero-length phases, delays close to the period, restarts in mid-count and the zero limit all fit inside a short run. A behavioural model compares every output on every cycle.

// File: rtl/sdmcw_pkg.sv
// Shared types for the card clock and watchdog block.
package sdmcw_pkg;
    // Level of the card clock phase being generated.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } clk_phase_e;

    // Number of sample strobe lanes (command, data).
    localparam int SMP_LANES = 2;
endpackage

// File: rtl/sdmcw_clk_div.sv
// Card clock divider. Generates a low phase of act_lo cycles followed by a
// high phase of act_hi cycles. Pending counts are adopted only when a high
// phase ends, so no period is ever cut short.
// Assumes pend_hi/pend_lo are held in registers by the parent.
module sdmcw_clk_div
    import sdmcw_pkg::*;
#(
    parameter int PH_W   = 8,
    parameter int DEF_HI = 4,
    parameter int DEF_LO = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] pend_hi,
    input  logic [PH_W-1:0] pend_lo,
    output logic            card_clk,
    output logic            rise_evt,
    output logic [PH_W-1:0] act_hi,
    output logic [PH_W-1:0] act_lo
);
    localparam logic [PH_W-1:0] ONE = PH_W'(1);

    clk_phase_e      phase;
    logic [PH_W-1:0] cnt;
    logic            fall_evt;

    // Map a zero count to one so the clock always toggles.
    function automatic logic [PH_W-1:0] nz(input logic [PH_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    // Phase end detection from the active counts.
    always_comb begin
        rise_evt = (phase == PH_LOW)  && (cnt >= act_lo - ONE);
        fall_evt = (phase == PH_HIGH) && (cnt >= act_hi - ONE);
    end

    // Phase counter and level; reload active counts at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_LOW;
            cnt    <= '0;
            act_hi <= nz(PH_W'(DEF_HI));
            act_lo <= nz(PH_W'(DEF_LO));
        end else if (rise_evt) begin
            phase <= PH_HIGH;
            cnt   <= '0;
        end else if (fall_evt) begin
            phase  <= PH_LOW;
            cnt    <= '0;
            act_hi <= nz(pend_hi);
            act_lo <= nz(pend_lo);
        end else begin
            cnt <= cnt + ONE;
        end
    end

    assign card_clk = (phase == PH_HIGH);
endmodule

// File: rtl/sdmcw_smp_dly.sv
// Sample strobe delay. On each trigger (a rising card clock transition)
// loads the delay; emits a one-cycle strobe that many cycles after the
// first high cycle. A new trigger restarts a pending delay.
module sdmcw_smp_dly #(
    parameter int SMP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [SMP_W-1:0] dly,
    output logic             strobe
);
    localparam logic [SMP_W-1:0] ONE = SMP_W'(1);

    logic [SMP_W-1:0] cnt;
    logic             busy;

    // Countdown from trigger to strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            busy   <= 1'b0;
            strobe <= 1'b0;
        end else if (trig) begin
            cnt    <= dly;
            busy   <= (dly != '0);
            strobe <= (dly == '0);
        end else if (busy) begin
            cnt    <= cnt - ONE;
            busy   <= (cnt != ONE);
            strobe <= (cnt == ONE);
        end else begin
            strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/sdmcw_wdog.sv
// Watchdog counting card clock periods. A start strobe clears the count and
// captures the limit; the timeout pulses once when the count reaches the
// limit, after which the watchdog idles. A zero limit never expires.
module sdmcw_wdog #(
    parameter int WD_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            tick,
    input  logic [WD_W-1:0] limit,
    output logic            timeout
);
    localparam logic [WD_W-1:0] ONE = WD_W'(1);

    logic [WD_W-1:0] cnt;
    logic [WD_W-1:0] lim_q;
    logic            run;
    logic            hit;

    // Limit reached on this tick.
    always_comb hit = run && tick && (lim_q != '0) && (cnt + ONE == lim_q);

    // Period counter, run flag and timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            lim_q   <= '0;
            run     <= 1'b0;
            timeout <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            lim_q   <= limit;
            run     <= 1'b1;
            timeout <= 1'b0;
        end else begin
            timeout <= hit;
            if (hit) begin
                run <= 1'b0;
            end
            if (run && tick) begin
                cnt <= cnt + ONE;
            end
        end
    end
endmodule

// File: rtl/sdmmc_clk_wdog.sv
// Top of the card clock block. Holds the pending phase counts (accepted only
// for slot 0), drives the divider, two sample strobe lanes and the watchdog.
// Assumes all inputs are synchronous to clk.
module sdmmc_clk_wdog
    import sdmcw_pkg::*;
#(
    parameter int PH_W   = 8,
    parameter int SMP_W  = 4,
    parameter int WD_W   = 24,
    parameter int SLOT_W = 2,
    parameter int DEF_HI = 4,
    parameter int DEF_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [PH_W-1:0]   cfg_hi,
    input  logic [PH_W-1:0]   cfg_lo,
    input  logic [SMP_W-1:0]  smp_cmd_dly,
    input  logic [SMP_W-1:0]  smp_dat_dly,
    input  logic [WD_W-1:0]   wd_limit,
    input  logic              wd_start,
    output logic              card_clk,
    output logic              cmd_smp,
    output logic              dat_smp,
    output logic              wd_timeout
);
    logic [PH_W-1:0]  pend_hi;
    logic [PH_W-1:0]  pend_lo;
    logic [PH_W-1:0]  act_hi;
    logic [PH_W-1:0]  act_lo;
    logic             rise_evt;
    logic [SMP_W-1:0] lane_dly [SMP_LANES];
    logic             lane_stb [SMP_LANES];

    // Pending counts: only writes addressed to slot 0 are taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_hi <= PH_W'(DEF_HI);
            pend_lo <= PH_W'(DEF_LO);
        end else if (cfg_wr && (cfg_slot == '0)) begin
            pend_hi <= cfg_hi;
            pend_lo <= cfg_lo;
        end
    end

    sdmcw_clk_div #(
        .PH_W   (PH_W),
        .DEF_HI (DEF_HI),
        .DEF_LO (DEF_LO)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_hi  (pend_hi),
        .pend_lo  (pend_lo),
        .card_clk (card_clk),
        .rise_evt (rise_evt),
        .act_hi   (act_hi),
        .act_lo   (act_lo)
    );

    assign lane_dly[0] = smp_cmd_dly;
    assign lane_dly[1] = smp_dat_dly;

    for (genvar g = 0; g < SMP_LANES; g++) begin : g_lane
        sdmcw_smp_dly #(
            .SMP_W (SMP_W)
        ) u_smp (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig   (rise_evt),
            .dly    (lane_dly[g]),
            .strobe (lane_stb[g])
        );
    end

    assign cmd_smp = lane_stb[0];
    assign dat_smp = lane_stb[1];

    sdmcw_wdog #(
        .WD_W (WD_W)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wd_start),
        .tick    (rise_evt),
        .limit   (wd_limit),
        .timeout (wd_timeout)
    );
endmodule

// File: rtl/sdmmc_clk_wdog_chk.sv
// Property checker for sdmmc_clk_wdog, attached by bind.
module sdmmc_clk_wdog_chk #(
    parameter int PH_W   = 8,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [SLOT_W-1:0] cfg_slot,
    input logic [PH_W-1:0]   pend_hi,
    input logic [PH_W-1:0]   pend_lo,
    input logic [PH_W-1:0]   act_hi,
    input logic [PH_W-1:0]   act_lo,
    input logic              card_clk,
    input logic              cmd_smp,
    input logic              dat_smp,
    input logic              wd_start,
    input logic              wd_timeout
);
    // R4: writes to other slots leave the pending counts untouched.
    assert_slot_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_slot != '0)) |=> ($stable(pend_hi) && $stable(pend_lo)));

    // R5: active counts change only on a falling card clock edge.
    assert_period_end_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_hi) || !$stable(act_lo)) |-> $fell(card_clk));

    // R3: active counts are never zero.
    assert_nonzero_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hi != '0) && (act_lo != '0));

    // R6: command strobe is a single-cycle pulse.
    assert_cmd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_smp |=> !cmd_smp);

    // R7: data strobe is a single-cycle pulse.
    assert_dat_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dat_smp |=> !dat_smp);

    // R8: timeout lasts one cycle and coincides with a rising card clock.
    assert_timeout_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> !wd_timeout);
    assert_timeout_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |-> $rose(card_clk));

    // R9: a start suppresses a timeout in the following cycle.
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_start |=> !wd_timeout);
endmodule

bind sdmmc_clk_wdog sdmmc_clk_wdog_chk #(
    .PH_W   (PH_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_slot   (cfg_slot),
    .pend_hi    (pend_hi),
    .pend_lo    (pend_lo),
    .act_hi     (act_hi),
    .act_lo     (act_lo),
    .card_clk   (card_clk),
    .cmd_smp    (cmd_smp),
    .dat_smp    (dat_smp),
    .wd_start   (wd_start),
    .wd_timeout (wd_timeout)
);

// File: tb/sdmmc_clk_wdog_tb.sv
// Bench: behavioural reference model compared on every cycle plus
// directed measurements of periods and timeout pulses.
module sdmmc_clk_wdog_tb;
    localparam int PH_W = 6, SMP_W = 4, WD_W = 8, SLOT_W = 2;
    localparam int DEF_HI = 3, DEF_LO = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [SLOT_W-1:0] cfg_slot = '0;
    logic [PH_W-1:0]   cfg_hi = '0;
    logic [PH_W-1:0]   cfg_lo = '0;
    logic [SMP_W-1:0]  smp_cmd_dly = '0;
    logic [SMP_W-1:0]  smp_dat_dly = '0;
    logic [WD_W-1:0]   wd_limit = '0;
    logic              wd_start = 1'b0;
    logic              card_clk, cmd_smp, dat_smp, wd_timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tmo_seen = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    sdmmc_clk_wdog #(
        .PH_W(PH_W), .SMP_W(SMP_W), .WD_W(WD_W), .SLOT_W(SLOT_W),
        .DEF_HI(DEF_HI), .DEF_LO(DEF_LO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_slot(cfg_slot),
        .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .smp_cmd_dly(smp_cmd_dly),
        .smp_dat_dly(smp_dat_dly), .wd_limit(wd_limit), .wd_start(wd_start),
        .card_clk(card_clk), .cmd_smp(cmd_smp), .dat_smp(dat_smp),
        .wd_timeout(wd_timeout)
    );

    always #5 clk = ~clk;

    // Reference model state.
    int m_lvl, m_cnt, m_hi, m_lo, m_phi, m_plo;
    int m_sc[2], m_sb[2], m_so[2];
    int m_run, m_wc, m_lim, m_to;

    function automatic int at_least1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        int rise;
        int d;
        rise = 0;
        if (!rst_n) begin
            m_lvl = 0; m_cnt = 0;
            m_hi = DEF_HI; m_lo = DEF_LO; m_phi = DEF_HI; m_plo = DEF_LO;
            for (int i = 0; i < 2; i++) begin m_sc[i] = 0; m_sb[i] = 0; m_so[i] = 0; end
            m_run = 0; m_wc = 0; m_lim = 0; m_to = 0;
        end else begin
            if (m_lvl == 0) begin
                if (m_cnt + 1 >= m_lo) begin m_lvl = 1; m_cnt = 0; rise = 1; end
                else m_cnt++;
            end else begin
                if (m_cnt + 1 >= m_hi) begin
                    m_lvl = 0; m_cnt = 0;
                    m_hi = at_least1(m_phi); m_lo = at_least1(m_plo);
                end else m_cnt++;
            end
            if (cfg_wr && cfg_slot == 0) begin m_phi = int'(cfg_hi); m_plo = int'(cfg_lo); end
            for (int i = 0; i < 2; i++) begin
                d = (i == 0) ? int'(smp_cmd_dly) : int'(smp_dat_dly);
                m_so[i] = 0;
                if (rise) begin
                    if (d == 0) begin m_so[i] = 1; m_sb[i] = 0; end
                    else begin m_sc[i] = d; m_sb[i] = 1; end
                end else if (m_sb[i]) begin
                    if (m_sc[i] == 1) begin m_so[i] = 1; m_sb[i] = 0; end
                    m_sc[i]--;
                end
            end
            m_to = 0;
            if (wd_start) begin m_run = 1; m_wc = 0; m_lim = int'(wd_limit); end
            else if (m_run && rise) begin
                if (m_lim != 0 && m_wc + 1 == m_lim) begin m_to = 1; m_run = 0; end
                m_wc++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (wd_timeout) tmo_seen++;
        if (rst_n && !done) begin
            check(cur_req, int'(card_clk), m_lvl, "card_clk");
            check((cur_req == "R6") ? "R6" : cur_req, int'(cmd_smp), m_so[0], "cmd_smp");
            check((cur_req == "R7") ? "R7" : cur_req, int'(dat_smp), m_so[1], "dat_smp");
            check(cur_req, int'(wd_timeout), m_to, "wd_timeout");
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int slot, input int hi, input int lo);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_slot = SLOT_W'(slot); cfg_hi = PH_W'(hi); cfg_lo = PH_W'(lo);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic start_wd(input int lim);
        @(negedge clk);
        wd_start = 1'b1; wd_limit = WD_W'(lim);
        @(negedge clk);
        wd_start = 1'b0;
    endtask

    // Cycles from one rising card clock to the next, seen at negedges.
    task automatic measure_period(output int per, output int hi_len);
        int prev;
        prev = int'(card_clk);
        forever begin @(negedge clk); if (card_clk && prev == 0) break; prev = int'(card_clk); end
        per = 0; hi_len = 0;
        prev = 1;
        forever begin
            per++;
            if (card_clk) hi_len++;
            @(negedge clk);
            if (card_clk && prev == 0) break;
            prev = int'(card_clk);
        end
    endtask

    // Run watchdog: an expired timer is a failed check.
    initial begin
        while (cycles < 100000 && !done) @(negedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, hl;
        idle(4);
        // R1: outputs quiet in reset
        check("R1", int'(card_clk | cmd_smp | dat_smp | wd_timeout), 0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(card_clk | cmd_smp | dat_smp | wd_timeout), 0, "outputs after reset");
        cur_req = "R2";
        measure_period(per, hl);
        check("R2", per, DEF_HI + DEF_LO, "default period");
        check("R2", hl, DEF_HI, "default high length");

        cur_req = "R5";
        write_cfg(0, 2, 5);
        idle(12);
        measure_period(per, hl);
        check("R5", per, 7, "period after update");
        check("R2", hl, 2, "high length after update");

        cur_req = "R4";
        write_cfg(1, 9, 9);
        write_cfg(3, 1, 1);
        idle(20);
        measure_period(per, hl);
        check("R4", per, 7, "period after other-slot writes");

        cur_req = "R3";
        write_cfg(0, 0, 0);
        idle(20);
        measure_period(per, hl);
        check("R3", per, 2, "zero counts period");
        check("R3", hl, 1, "zero counts high length");

        cur_req = "R6";
        smp_cmd_dly = 4'd2; smp_dat_dly = 4'd0;
        write_cfg(0, 3, 4);
        idle(40);
        cur_req = "R7";
        smp_cmd_dly = 4'd0; smp_dat_dly = 4'd5;
        idle(40);

        cur_req = "R8";
        idle(3);
        tmo_seen = 0;
        start_wd(4);
        idle(60);
        check("R8", tmo_seen, 1, "timeout pulses for limit 4");

        cur_req = "R9";
        tmo_seen = 0;
        start_wd(5);
        idle(12);
        start_wd(5);
        idle(20);
        check("R9", tmo_seen, 0, "no early timeout after restart");
        idle(40);
        check("R9", tmo_seen, 1, "one timeout after restart");

        cur_req = "R10";
        tmo_seen = 0;
        start_wd(0);
        idle(80);
        check("R10", tmo_seen, 0, "zero limit timeouts");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule